// File: doc/BRIEF.md
# CPU Reset and Startup Sequencer

This block sits between a board-level reset line and a processor core. The reset line is active high and may change at any time, so the block first brings it into the clock domain through a short flop chain. From then on the core is held dormant for as long as the synchronized reset stays high. While the reset lasts, the address/data drivers are floated and the latch-enable and hold-acknowledge outputs are forced low. The bus status lines are driven to the passive code for the first clock only and are then released.

When reset falls, the block runs a fixed seven-clock initialization phase and then enables the core, which fetches from the reset vector address FFFF0h. A non-maskable interrupt is suppressed during reset and during the first clock after reset ends, and is passed through from the second clock onwards. If a hold request is pending when initialization ends, the bus is granted before the core is allowed to run. A reset that lasts four synchronized clocks or fewer is flagged as too short, but it is still carried out in full.

Top module: `cpu_startup_seq`

## Requirements
- R1: The reset input passes through two synchronizer flops. core_run_o goes low at the third rising clock edge after reset_req_i is first sampled high, and it stays low while the synchronized reset is high.
- R2: After reset_req_i is first sampled low, core_run_o rises at exactly the tenth rising edge: two synchronizer edges, one edge to leave reset, and seven initialization clocks. This holds when no hold request is pending.
- R3: start_addr_o always carries the reset vector, 20'hFFFF0.
- R4: short_pulse_o is updated when reset ends, three edges after reset_req_i is sampled low. It is set to 1 if the reset was high for 4 sampled clocks or fewer and to 0 if it was high for 5 or more. It is cleared at the edge where the synchronized reset rises again. A short reset still runs the full startup of R2.
- R5: nmi_ok_o is 0 during reset and during the first initialization clock. From the second clock after reset ends it equals nmi_i.
- R6: bus_float_o is 1 in reset and in startup hold, and 0 during initialization and run. ale_o and hold_ack_o are 0 during reset and initialization, whatever core_ale_i and core_hlda_i do. In run, ale_o and hold_ack_o follow core_ale_i and core_hlda_i.
- R7: status_oe_o and status_idle_o are both 1 for exactly the first clock of a reset entered from a non-reset state. After that clock, status_oe_o is 0 while status_idle_o stays 1 until reset ends.
- R8: If hold_req_i is 1 when initialization ends, the block enters startup hold with hold_ack_o=1 and core_run_o=0. core_run_o rises at the first edge that samples hold_req_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Power-on asynchronous reset of the sequencer itself, active low |
| reset_req_i | input | 1 | Asynchronous CPU reset request, active high |
| nmi_i | input | 1 | Raw non-maskable interrupt request |
| hold_req_i | input | 1 | Bus hold request from another master |
| core_ale_i | input | 1 | Address latch enable from the core |
| core_hlda_i | input | 1 | Hold acknowledge from the core |
| core_run_o | output | 1 | Core may execute |
| start_addr_o | output | 20 | First fetch address |
| bus_float_o | output | 1 | Float the tri-state bus drivers |
| ale_o | output | 1 | Gated address latch enable |
| hold_ack_o | output | 1 | Hold acknowledge to the bus |
| status_oe_o | output | 1 | Drive bus status lines |
| status_idle_o | output | 1 | Force passive code on status lines |
| nmi_ok_o | output | 1 | Qualified NMI to the core |
| short_pulse_o | output | 1 | Last reset was too short |

## Verification
The bench aims at the exact release latency. A synchronizer stage too many or too few, or an initialization count off by one, moves the rise of core_run_o away from the tenth edge. It probes the NMI blanking edge one clock on each side, where an off-by-one window would either leak or swallow an interrupt. Reset pulses of 3, 4 and 5 clocks bracket the width limit: an inclusive/exclusive mix-up would flag the 5-clock pulse or pass the 4-clock one. Further cases check that the status outputs are driven for only one reset clock, that core strobes are masked during initialization, and that a pending hold delays the first fetch until it is dropped.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_INIT  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/width_monitor.sv
module width_monitor #(
  parameter int MIN_WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_sync_i,
  output logic short_o
);
  localparam int SAT = MIN_WIDTH + 1;
  localparam int CW  = $clog2(SAT + 1);

  logic          rst_q;
  logic [CW-1:0] wid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b1;
      wid_q   <= '0;
      short_o <= 1'b0;
    end else begin
      rst_q <= rst_sync_i;
      if (rst_sync_i) begin
        if (!rst_q)                   wid_q <= CW'(1);
        else if (wid_q != CW'(SAT))   wid_q <= wid_q + CW'(1);
      end
      if (rst_sync_i && !rst_q)       short_o <= 1'b0;
      else if (!rst_sync_i && rst_q)  short_o <= (wid_q <= CW'(MIN_WIDTH));
    end
  end

  // R4: a new reset clears the flag
  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sync_i && !rst_q) |=> !short_o);
  // R4: flag only moves at a reset boundary
  p_flag_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sync_i == rst_q) |=> $stable(short_o));
endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
  import startup_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 7,
  parameter int NMI_BLANK   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_sync_i,
  input  logic nmi_i,
  input  logic hold_req_i,
  input  logic core_ale_i,
  input  logic core_hlda_i,
  output logic core_run_o,
  output logic bus_float_o,
  output logic ale_o,
  output logic hold_ack_o,
  output logic status_oe_o,
  output logic status_idle_o,
  output logic nmi_ok_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  seq_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RESET;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= rst_sync_i && (st_q != ST_RESET);
      if (rst_sync_i) begin
        st_q  <= ST_RESET;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          ST_RESET: begin
            st_q  <= ST_INIT;
            cnt_q <= '0;
          end
          ST_INIT: begin
            if (cnt_q == LAST) st_q <= hold_req_i ? ST_HOLD : ST_RUN;
            else               cnt_q <= cnt_q + CW'(1);
          end
          ST_HOLD: if (!hold_req_i) st_q <= ST_RUN;
          default: ;
        endcase
      end
    end
  end

  logic nmi_open;
  assign nmi_open = (st_q == ST_RUN) || (st_q == ST_HOLD) ||
                    ((st_q == ST_INIT) && (cnt_q >= CW'(NMI_BLANK)));

  assign core_run_o    = (st_q == ST_RUN);
  assign bus_float_o   = (st_q == ST_RESET) || (st_q == ST_HOLD);
  assign ale_o         = (st_q == ST_RUN) && core_ale_i;
  assign hold_ack_o    = (st_q == ST_HOLD) || ((st_q == ST_RUN) && core_hlda_i);
  assign status_idle_o = (st_q == ST_RESET);
  assign status_oe_o   = (st_q != ST_RESET) || first_q;
  assign nmi_ok_o      = nmi_i && nmi_open;

  p_run_stops_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sync_i |=> !core_run_o);
  p_init_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INIT && cnt_q != LAST && !rst_sync_i) |=> (st_q == ST_INIT));
  p_init_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INIT && cnt_q == LAST && !rst_sync_i && !hold_req_i) |=> core_run_o);
  p_nmi_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESET) |-> !nmi_ok_o);
  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INIT) |-> (!ale_o && !hold_ack_o && !bus_float_o));
  p_status_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESET && status_oe_o) |=> (!status_oe_o || st_q != ST_RESET));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> (hold_ack_o && !core_run_o));
endmodule

// File: rtl/cpu_startup_seq.sv
module cpu_startup_seq #(
  parameter int          ADDR_W      = 20,
  parameter logic [19:0] RESET_VEC   = 20'hFFFF0,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_WIDTH   = 4,
  parameter int          INIT_CYCLES = 7,
  parameter int          NMI_BLANK   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_req_i,
  input  logic              nmi_i,
  input  logic              hold_req_i,
  input  logic              core_ale_i,
  input  logic              core_hlda_i,
  output logic              core_run_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              bus_float_o,
  output logic              ale_o,
  output logic              hold_ack_o,
  output logic              status_oe_o,
  output logic              status_idle_o,
  output logic              nmi_ok_o,
  output logic              short_pulse_o
);
  logic rst_sync;

  reset_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (reset_req_i),
    .q_o    (rst_sync)
  );

  width_monitor #(.MIN_WIDTH(MIN_WIDTH)) i_width (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_i (rst_sync),
    .short_o    (short_pulse_o)
  );

  startup_fsm #(.INIT_CYCLES(INIT_CYCLES), .NMI_BLANK(NMI_BLANK)) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_sync_i    (rst_sync),
    .nmi_i         (nmi_i),
    .hold_req_i    (hold_req_i),
    .core_ale_i    (core_ale_i),
    .core_hlda_i   (core_hlda_i),
    .core_run_o    (core_run_o),
    .bus_float_o   (bus_float_o),
    .ale_o         (ale_o),
    .hold_ack_o    (hold_ack_o),
    .status_oe_o   (status_oe_o),
    .status_idle_o (status_idle_o),
    .nmi_ok_o      (nmi_ok_o)
  );

  assign start_addr_o = ADDR_W'(RESET_VEC);

  // R3: vector is constant out of reset
  p_vector_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_run_o) |-> (start_addr_o == ADDR_W'(RESET_VEC)));
endmodule

// File: tb/test_cpu_startup_seq.sv
module test_cpu_startup_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reset_req_i = 1'b1;
  logic        nmi_i = 1'b0;
  logic        hold_req_i = 1'b0;
  logic        core_ale_i = 1'b0;
  logic        core_hlda_i = 1'b0;
  logic        core_run_o, bus_float_o, ale_o, hold_ack_o;
  logic        status_oe_o, status_idle_o, nmi_ok_o, short_pulse_o;
  logic [19:0] start_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  cpu_startup_seq i_cpu_startup_seq (
    .clk_i, .rst_ni, .reset_req_i, .nmi_i, .hold_req_i, .core_ale_i, .core_hlda_i,
    .core_run_o, .start_addr_o, .bus_float_o, .ale_o, .hold_ack_o,
    .status_oe_o, .status_idle_o, .nmi_ok_o, .short_pulse_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // hold reset_req_i high for width sampled clocks; optional checks when leaving run
  task automatic raise_reset(int width, bit chk);
    @(negedge clk_i);
    reset_req_i = 1'b1;
    core_ale_i  = 1'b1;
    core_hlda_i = 1'b1;
    for (int i = 1; i <= width; i++) begin
      @(negedge clk_i);
      if (chk && i == 2) check("R1 run before sync", core_run_o, 1);
      if (chk && i == 3) begin
        check("R1 run stopped", core_run_o, 0);
        check("R7 status driven first clk", status_oe_o, 1);
        check("R7 status idle", status_idle_o, 1);
        check("R6 float in reset", bus_float_o, 1);
        check("R6 ale low in reset", ale_o, 0);
        check("R6 hlda low in reset", hold_ack_o, 0);
        check("R4 flag cleared by new reset", short_pulse_o, 0);
      end
      if (chk && i == 4 && width >= 4) begin
        check("R7 status floats", status_oe_o, 0);
        check("R7 status idle held", status_idle_o, 1);
      end
      if (i == width) reset_req_i = 1'b0;
    end
  endtask

  // reset_req_i was just lowered at this negedge
  task automatic release_measure(string tag, bit exp_short, bit hold);
    int got = 0;
    nmi_i = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk_i);
      if (k == 3) begin
        check({"R4 width flag ", tag}, short_pulse_o, exp_short);
        check("R5 nmi blanked first init clk", nmi_ok_o, 0);
        check("R6 no float in init", bus_float_o, 0);
        check("R6 ale masked in init", ale_o, 0);
        check("R6 hlda masked in init", hold_ack_o, 0);
      end
      if (k == 4) check("R5 nmi passes second clk", nmi_ok_o, 1);
      if (hold && k == 10) begin
        check("R8 hold granted", hold_ack_o, 1);
        check("R8 core held", core_run_o, 0);
        check("R8 float in hold", bus_float_o, 1);
        got = k;
        break;
      end
      if (core_run_o) begin
        got = k;
        break;
      end
    end
    nmi_i = 1'b0;
    if (!hold) check({"R2 release latency ", tag}, got, 10);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 dormant in reset", core_run_o, 0);
    check("R3 vector", start_addr_o, 20'hFFFF0);
    check("R6 float at power-up", bus_float_o, 1);
    check("R5 nmi blocked in reset", nmi_ok_o, 0);
    nmi_i = 1'b1;
    @(negedge clk_i);
    check("R5 nmi blocked in reset raw high", nmi_ok_o, 0);
    nmi_i = 1'b0;
    reset_req_i = 1'b0;
    release_measure("power-up", 1'b0, 1'b0);
  endtask

  task automatic t_run_passthrough();
    @(negedge clk_i);
    core_ale_i = 1'b1; core_hlda_i = 1'b0;
    @(negedge clk_i);
    check("R6 ale follows core", ale_o, 1);
    check("R6 hlda follows core", hold_ack_o, 0);
    check("R3 vector in run", start_addr_o, 20'hFFFF0);
    core_ale_i = 1'b0; core_hlda_i = 1'b1;
    @(negedge clk_i);
    check("R6 ale follows core low", ale_o, 0);
    check("R6 hlda follows core high", hold_ack_o, 1);
  endtask

  task automatic t_width(int w, bit exp_short);
    string tag;
    tag = $sformatf("w%0d", w);
    raise_reset(w, 1'b1);
    release_measure(tag, exp_short, 1'b0);
  endtask

  task automatic t_hold();
    raise_reset(6, 1'b1);
    hold_req_i = 1'b1;
    release_measure("hold", 1'b0, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R8 still held", core_run_o, 0);
    hold_req_i = 1'b0;
    core_hlda_i = 1'b0;
    @(negedge clk_i);
    check("R8 run after hold drop", core_run_o, 1);
    check("R8 hlda released", hold_ack_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    t_reset_state();
    t_run_passthrough();
    t_width(3, 1'b1);
    t_width(4, 1'b1);
    t_width(5, 1'b0);
    t_width(8, 1'b0);
    t_hold();
    summary();
  end
endmodule